// File: doc/BRIEF.md
# Passive LCD Raster Timing Generator

This block drives a monochrome passive LCD panel that takes four pixels at a time on a 4-bit data port. It pulls groups of four pixel bits from a fetch port with a valid/ready handshake, in raster order. For each group it drives the data bus and gives one pulse on the nibble clock. The panel captures the data on the falling edge of that clock.

After the last group of a line, the block pulses a line strobe. The nibble clock stays low during the strobe, so its low time at each line end is twice the normal low time. The frame sync pulses together with the strobe of the bottom row, which returns the panel to row zero. The AC-bias output is high during a programmed number of nibble-clock pulses at the start of every line.

The nibble rate comes from a clock-enable divider. Each phase of the nibble clock lasts `cfg_div + 1` system clocks. The panel width (a multiple of 4, at least 4), the height and the bias length are static inputs.

Top module: `lcd_raster_gen`

## Requirements
- R1: While reset is held and after it is released, up to the first nibble-clock rising edge, `lcd_data`, `lcd_nclk`, `lcd_line`, `lcd_frame` and `lcd_bias` are all low.
- R2: When fetch data is always valid, each nibble-clock high phase lasts `cfg_div+1` clocks, and each low phase between two groups of the same line also lasts `cfg_div+1` clocks.
- R3: Each accepted 4-bit word appears unchanged on `lcd_data` (bit i to bit i) at the nibble-clock rising edge. It stays there until after the falling edge. Words go out in the order they were accepted, and `lcd_data` changes only at a rising edge.
- R4: Between two line strobes there are exactly `cfg_width/4` nibble-clock pulses.
- R5: The line strobe rises on the same clock as the falling edge of the last pulse of a line. It lasts `cfg_div+1` clocks, and the nibble clock is low throughout. The low time before the next pulse is then `2*(cfg_div+1)` clocks.
- R6: The frame sync is high exactly during the line strobe of row `cfg_height-1`, counting rows from 0 after reset. It is never high without the strobe, and the row count then wraps to 0.
- R7: At the rising edge of pulse k of a line (k counted from 0), `lcd_bias` becomes 1 if k < `cfg_bias_len`, else 0. It is low during the line strobe. With `cfg_bias_len` = 0 it never goes high.
- R8: `pix_ready` is high only during a low phase of the nibble clock, on the divider tick. While `pix_valid` is low the nibble clock stays low and no word is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_width | input | WIDTH_W | Panel width in pixels, multiple of 4 |
| cfg_height | input | HEIGHT_W | Panel height in rows |
| cfg_bias_len | input | BIAS_W | Nibble pulses per line with bias high |
| cfg_div | input | DIV_W | Clocks per nibble-clock phase minus one |
| pix_valid | input | 1 | Fetch word available |
| pix_data | input | 4 | Four pixel bits, bit 0 first on the panel |
| pix_ready | output | 1 | Word taken this clock when valid |
| lcd_data | output | 4 | Panel data bus |
| lcd_nclk | output | 1 | Nibble clock |
| lcd_line | output | 1 | Line strobe |
| lcd_frame | output | 1 | Frame sync |
| lcd_bias | output | 1 | AC-bias drive |

## Verification
The bench measures every low phase of the nibble clock. A design that did not hold the clock low across the strobe would show a line-end gap of one phase instead of two. It counts pulses between strobes and follows the row index, so an off-by-one in the group count or in the frame row shows up as a wrong count or a frame sync on the wrong line. It uses bias lengths of zero, of less than the line and of more than the line, which catches a comparison that is inclusive or that wraps. It also stalls the fetch port in the middle of a line, which exposes a clock that keeps toggling or a word that is dropped or sent twice.

// File: rtl/lcd_raster_gen.sv
module lcd_raster_gen #(
  parameter int WIDTH_W  = 10,
  parameter int HEIGHT_W = 10,
  parameter int BIAS_W   = 8,
  parameter int DIV_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [WIDTH_W-1:0]  cfg_width,
  input  logic [HEIGHT_W-1:0] cfg_height,
  input  logic [BIAS_W-1:0]   cfg_bias_len,
  input  logic [DIV_W-1:0]    cfg_div,
  input  logic                pix_valid,
  input  logic [3:0]          pix_data,
  output logic                pix_ready,
  output logic [3:0]          lcd_data,
  output logic                lcd_nclk,
  output logic                lcd_line,
  output logic                lcd_frame,
  output logic                lcd_bias
);
  localparam int NIB_W = WIDTH_W - 2;

  typedef enum logic [1:0] {PH_LOW, PH_HIGH, PH_STRB} phase_t;

  phase_t              phase;
  logic [DIV_W-1:0]    div_cnt;
  logic [NIB_W-1:0]    nib_cnt;
  logic [HEIGHT_W-1:0] row_cnt;
  logic                tick;
  logic [NIB_W-1:0]    nib_last;
  logic [HEIGHT_W-1:0] row_last;

  assign tick      = (div_cnt >= cfg_div);
  assign nib_last  = cfg_width[WIDTH_W-1:2] - NIB_W'(1);
  assign row_last  = cfg_height - HEIGHT_W'(1);
  assign pix_ready = tick && (phase == PH_LOW);

  always_ff @(posedge clk) begin
    if (!rst_n) div_cnt <= '0;
    else if (tick) div_cnt <= '0;
    else div_cnt <= div_cnt + DIV_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_LOW;
      nib_cnt   <= '0;
      row_cnt   <= '0;
      lcd_data  <= '0;
      lcd_nclk  <= 1'b0;
      lcd_line  <= 1'b0;
      lcd_frame <= 1'b0;
      lcd_bias  <= 1'b0;
    end else if (tick) begin
      case (phase)
        PH_LOW: if (pix_valid) begin
          phase    <= PH_HIGH;
          lcd_nclk <= 1'b1;
          lcd_data <= pix_data;
          lcd_bias <= (32'(nib_cnt) < 32'(cfg_bias_len));
        end
        PH_HIGH: begin
          lcd_nclk <= 1'b0;
          if (nib_cnt == nib_last) begin
            phase     <= PH_STRB;
            lcd_line  <= 1'b1;
            lcd_frame <= (row_cnt == row_last);
            lcd_bias  <= 1'b0;
            nib_cnt   <= '0;
            row_cnt   <= (row_cnt == row_last) ? '0 : row_cnt + HEIGHT_W'(1);
          end else begin
            phase   <= PH_LOW;
            nib_cnt <= nib_cnt + NIB_W'(1);
          end
        end
        default: begin
          phase     <= PH_LOW;
          lcd_line  <= 1'b0;
          lcd_frame <= 1'b0;
        end
      endcase
    end
  end

  // R5
  nclk_low_in_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_line |-> !lcd_nclk);

  // R6
  frame_within_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_frame |-> lcd_line);

  // R3
  data_moves_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(lcd_nclk) |-> $stable(lcd_data));

  // R7
  bias_off_in_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_line |-> !lcd_bias);

  // R8
  ready_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> (!lcd_nclk && !lcd_line));

endmodule

// File: tb/lcd_raster_gen_tb.sv
module lcd_raster_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] cfg_width = 10'd16;
  logic [9:0] cfg_height = 10'd3;
  logic [7:0] cfg_bias_len = 8'd2;
  logic [7:0] cfg_div = 8'd1;
  logic       pix_valid = 1'b0;
  logic [3:0] pix_data = 4'd0;
  logic       pix_ready;
  logic [3:0] lcd_data;
  logic       lcd_nclk, lcd_line, lcd_frame, lcd_bias;

  lcd_raster_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_height(cfg_height),
    .cfg_bias_len(cfg_bias_len), .cfg_div(cfg_div), .pix_valid(pix_valid),
    .pix_data(pix_data), .pix_ready(pix_ready), .lcd_data(lcd_data),
    .lcd_nclk(lcd_nclk), .lcd_line(lcd_line), .lcd_frame(lcd_frame),
    .lcd_bias(lcd_bias)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [3:0] exp_q[$];
  int  seed = 0;
  bit  adv = 0;
  bit  mon_en = 0;
  bit  stall_flag = 0;
  int  accepted = 0;
  int  T = 2, W = 16, H = 3, B = 2;

  int  low_len, hi_len, line_len, nib_in_line, row, lines_done;
  bit  first_rise, strobe_seen, prev_nclk, prev_line;
  logic [3:0] prev_data;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // driver: pushes each accepted word into the scoreboard
  always @(negedge clk) begin
    if (mon_en && pix_valid && pix_ready) begin
      exp_q.push_back(pix_data);
      accepted++;
      adv = 1;
    end
  end

  always @(posedge clk) begin
    if (adv) begin
      #1;
      seed = seed + 1;
      pix_data = 4'((seed * 7 + 3) ^ (seed >> 2));
      adv = 0;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (mon_en) begin
      if (lcd_nclk && !prev_nclk) begin
        if (!first_rise && !stall_flag)
          chk(low_len == (strobe_seen ? 2*T : T), strobe_seen ? "R5 line-end low" : "R2 low phase",
              low_len, strobe_seen ? 2*T : T);
        chk(lcd_bias == (nib_in_line < B), "R7 bias", lcd_bias, int'(nib_in_line < B));
        first_rise = 0; stall_flag = 0; strobe_seen = 0; hi_len = 1;
      end else if (lcd_nclk) hi_len++;
      if (!lcd_nclk && prev_nclk) begin
        chk(hi_len == T, "R2 high phase", hi_len, T);
        if (exp_q.size() == 0) chk(0, "R3 empty scoreboard", lcd_data, -1);
        else begin
          logic [3:0] e;
          e = exp_q.pop_front();
          chk(lcd_data == e, "R3 data", lcd_data, e);
        end
        nib_in_line++;
        low_len = 1;
      end else if (!lcd_nclk) low_len++;
      if (lcd_data != prev_data && !(lcd_nclk && !prev_nclk))
        chk(0, "R3 data moved off rise", lcd_data, prev_data);
      if (lcd_line && !prev_line) begin
        chk(nib_in_line == W/4, "R4 pulses per line", nib_in_line, W/4);
        chk(lcd_frame == (row == H-1), "R6 frame row", lcd_frame, int'(row == H-1));
        chk(!lcd_nclk, "R5 nclk low in strobe", lcd_nclk, 0);
        row = (row == H-1) ? 0 : row + 1;
        nib_in_line = 0; strobe_seen = 1; line_len = 1; lines_done++;
      end else if (lcd_line) line_len++;
      if (!lcd_line && prev_line) chk(line_len == T, "R5 strobe length", line_len, T);
      if (lcd_frame && !lcd_line) chk(0, "R6 frame without strobe", 1, 0);
    end
    prev_nclk = lcd_nclk; prev_line = lcd_line; prev_data = lcd_data;
  end

  task automatic run_cfg(input int w, input int h, input int b, input int d,
                         input int nlines, input bit do_stall);
    mon_en = 0; pix_valid = 0; rst_n = 0;
    cfg_width = 10'(w); cfg_height = 10'(h); cfg_bias_len = 8'(b); cfg_div = 8'(d);
    W = w; H = h; B = b; T = d + 1;
    repeat (3) @(negedge clk);
    chk({lcd_data, lcd_nclk, lcd_line, lcd_frame, lcd_bias} == 8'd0, "R1 in reset",
        {lcd_data, lcd_nclk, lcd_line, lcd_frame, lcd_bias}, 0);
    exp_q.delete();
    low_len = 0; hi_len = 0; line_len = 0; nib_in_line = 0; row = 0; lines_done = 0;
    first_rise = 1; strobe_seen = 0; stall_flag = 0;
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk({lcd_data, lcd_nclk, lcd_line, lcd_frame, lcd_bias} == 8'd0, "R1 after release",
        {lcd_data, lcd_nclk, lcd_line, lcd_frame, lcd_bias}, 0);
    mon_en = 1; pix_valid = 1;
    if (do_stall) begin
      for (int g = 0; g < 20000 && lines_done < 1; g++) @(negedge clk);
      repeat (3*T + 1) @(negedge clk);
      pix_valid = 0; stall_flag = 1;
      repeat (4*T) @(negedge clk);
      begin
        int acc0, highs;
        acc0 = accepted; highs = 0;
        for (int i = 0; i < 6*T; i++) begin
          @(negedge clk);
          if (lcd_nclk) highs++;
        end
        chk(highs == 0, "R8 nclk held during stall", highs, 0);
        chk(accepted == acc0, "R8 no accept during stall", accepted, acc0);
      end
      stall_flag = 1;
      pix_valid = 1;
    end
    for (int g = 0; g < 40000 && lines_done < nlines; g++) @(negedge clk);
    chk(lines_done >= nlines, "R4 lines produced", lines_done, nlines);
    mon_en = 0; pix_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    run_cfg(16, 3, 2, 1, 8, 1);
    run_cfg(8, 2, 0, 0, 5, 0);
    run_cfg(12, 4, 5, 2, 6, 0);
    run_cfg(20, 2, 5, 0, 4, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule